// File: doc/BRIEF.md
# Retriggerable Prescaled Interval Timer

This block measures a programmable time interval and raises a one-cycle end-of-count interrupt when it expires. Time is counted from the system clock, first divided by a fixed factor of eight (a divide-by-two followed by a divide-by-four) and then by a programmable prescaler. The divided clock decrements an eight-bit down-counter that is loaded from a programmable initial count, so an interval lasts 8 × prescale × initial-count system clocks.

A four-bit mode register selects how the counter is started. In retriggerable mode, every falling edge on an asynchronous trigger input loads the counter and starts the interval again, so the interrupt only fires once the trigger has stayed quiet for a full interval. In the software mode, setting the enable bit starts the count and the trigger input has no effect on the counter. In both modes a single-pass setting stops the timer and clears the enable bit at end-of-count, while a continuous setting reloads and keeps counting. Each falling trigger edge also pulses a separate edge interrupt, whatever the mode.

Top module: `retrig_interval_timer`

## Requirements
- R1: After reset both interrupt outputs, the enable bit, the running flag and the count output are all 0.
- R2: With the trigger-select field (mode bits 3:2) equal to 2'b11 and the enable bit (mode bit 0) set, a falling edge on the trigger input starts the interval two clocks after it enters the synchroniser; irq_eoc then pulses for one cycle, 8 × prescale × initial-count clocks after the start.
- R3: A falling trigger edge while counting in retriggerable mode reloads the counter and the prescaler, so irq_eoc fires one full interval after the latest edge.
- R4: In single-pass operation (mode bit 1 clear) end-of-count clears the enable bit and the running flag; falling trigger edges are then ignored until software sets the enable bit again.
- R5: In continuous operation (mode bit 1 set) the timer reloads at end-of-count, keeps running, and pulses irq_eoc once every interval.
- R6: Every falling edge on the trigger input produces a one-cycle irq_edge pulse, independent of mode and enable.
- R7: A prescale value of 0 divides by 64 and an initial count of 0 counts 256.
- R8: When a trigger edge is detected in the same cycle as end-of-count, irq_eoc is still issued, the reload wins, and the timer stays running and enabled even in single-pass operation.
- R9: With the trigger-select field not equal to 2'b11, writing the enable bit from 0 to 1 starts the interval on that write, and trigger edges do not affect the counter.
- R10: Clearing the enable bit stops the timer at once; no irq_eoc follows until it is started again.
- R11: While running, count_o shows the remaining count (modulo 256), starting at the initial count and dropping by one every 8 × prescale clocks.
- R12: Initial-count and prescale writes take effect at the next load (a start or a continuous reload), not within the interval in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous trigger input, falling edges are events |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 4 | Mode value: bit 0 enable, bit 1 continuous, bits 3:2 trigger select |
| init_we | input | 1 | Write strobe for the initial count |
| init_wdata | input | CNT_W | Initial count, 0 means 256 |
| pre_we | input | 1 | Write strobe for the prescale value |
| pre_wdata | input | PRE_W | Prescale value, 0 means 64 |
| irq_eoc | output | 1 | One-cycle end-of-count interrupt pulse |
| irq_edge | output | 1 | One-cycle pulse per falling trigger edge |
| count_o | output | CNT_W | Current counter value |
| armed_o | output | 1 | Current enable bit |
| running_o | output | 1 | Timer is counting |

## Verification
The hardest situation to reach is a trigger edge that is detected in exactly the cycle the interval expires, because the edge passes through a synchroniser and the interval is tens of clocks long. The stimulus starts an interval from a known falling edge, then drives the second falling edge precisely three synchroniser-plus-detection clocks before the computed expiry, and checks that the interrupt, the running flag and the enable bit all survive the coincidence and that a full fresh interval follows. A behavioural model that tracks elapsed clocks since the last load is compared against every output on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Mode register layout
    localparam int MODE_W    = 4;
    localparam int MB_EN     = 0;
    localparam int MB_CONT   = 1;
    localparam int MB_TSEL_L = 2;
    localparam int MB_TSEL_H = 3;

    typedef enum logic [1:0] {
        TSEL_SOFT   = 2'b00,
        TSEL_RSV1   = 2'b01,
        TSEL_RSV2   = 2'b10,
        TSEL_RETRIG = 2'b11
    } tsel_e;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);

    localparam int LAST = STAGES;

    typedef struct packed {
        logic [LAST:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sh[0] = async_i;
        for (int i = 1; i <= LAST; i++) begin
            s_d.sh[i] = s_q.sh[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // previous synchronised level high, current low
    assign fall_o = s_q.sh[LAST] & ~s_q.sh[LAST-1];

    // R6
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int PRE_W = 6,
    parameter int DIV_A = 2,
    parameter int DIV_B = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             tick_o
);

    localparam int FIX_DIV = DIV_A * DIV_B;
    localparam int DIV_W   = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PRE_W-1:0] pre;
        logic [PRE_W-1:0] lat;
    } tick_t;

    tick_t t_d, t_q;
    logic  base_w;

    generate
        if (FIX_DIV > 1) begin : g_fixdiv
            assign base_w = (t_q.div == DIV_W'(FIX_DIV - 1));
        end else begin : g_nodiv
            assign base_w = 1'b1;
        end
    endgenerate

    assign tick_o = run_i & base_w & (t_q.pre == PRE_W'(1));

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.div = '0;
            t_d.pre = pre_i;
            t_d.lat = pre_i;
        end else if (run_i) begin
            t_d.div = base_w ? '0 : DIV_W'(t_q.div + 1'b1);
            if (base_w) begin
                // a value of 0 wraps to the all-ones value: full 2**PRE_W period
                t_d.pre = (t_q.pre == PRE_W'(1)) ? t_q.lat : PRE_W'(t_q.pre - 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R11
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R10
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(t_q.div) && $stable(t_q.pre));

endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] init_i,
    output logic             eoc_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t k_d, k_q;

    // counter stops at 1; the next tick is the wrap back to the reload value
    assign eoc_o = tick_i & (k_q.cnt == CNT_W'(1));
    assign cnt_o = k_q.cnt;

    always_comb begin
        k_d = k_q;
        if (load_i)      k_d.cnt = init_i;
        else if (tick_i) k_d.cnt = CNT_W'(k_q.cnt - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    // R12
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(init_i)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_o));

endmodule

// File: rtl/retrig_interval_timer.sv
module retrig_interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 6,
    parameter int DIV_A       = 2,
    parameter int DIV_B       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              init_we,
    input  logic [CNT_W-1:0]  init_wdata,
    input  logic              pre_we,
    input  logic [PRE_W-1:0]  pre_wdata,
    output logic              irq_eoc,
    output logic              irq_edge,
    output logic [CNT_W-1:0]  count_o,
    output logic              armed_o,
    output logic              running_o
);

    typedef struct packed {
        logic             en;
        logic             cont;
        tsel_e            tsel;
        logic             run;
        logic             irq_eoc;
        logic             irq_edge;
        logic [CNT_W-1:0] init;
        logic [PRE_W-1:0] pre;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic  fall_w;
    logic  tick_w;
    logic  eoc_w;
    logic  load_w;
    logic  hw_start_w;
    logic  sw_start_w;
    logic  start_w;
    logic  wr_en_w;
    logic  wr_cont_w;
    tsel_e wr_tsel_w;

    assign wr_en_w   = mode_wdata[MB_EN];
    assign wr_cont_w = mode_wdata[MB_CONT];
    assign wr_tsel_w = tsel_e'(mode_wdata[MB_TSEL_H:MB_TSEL_L]);

    tmr_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_in),
        .fall_o  (fall_w)
    );

    tmr_tick_gen #(
        .PRE_W (PRE_W),
        .DIV_A (DIV_A),
        .DIV_B (DIV_B)
    ) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (c_q.run),
        .load_i (load_w),
        .pre_i  (c_q.pre),
        .tick_o (tick_w)
    );

    tmr_down_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_w),
        .load_i (load_w),
        .init_i (c_q.init),
        .eoc_o  (eoc_w),
        .cnt_o  (count_o)
    );

    // start sources: trigger edge when armed in retriggerable mode,
    // or a software 0->1 enable write in any other mode
    assign hw_start_w = fall_w & c_q.en & (c_q.tsel == TSEL_RETRIG);
    assign sw_start_w = mode_we & wr_en_w & ~c_q.en & (wr_tsel_w != TSEL_RETRIG);
    assign start_w    = hw_start_w | sw_start_w;
    assign load_w     = start_w | eoc_w;

    always_comb begin
        c_d          = c_q;
        c_d.irq_eoc  = eoc_w;
        c_d.irq_edge = fall_w;

        if (start_w) begin
            c_d.run = 1'b1;
        end else if (eoc_w && !c_q.cont) begin
            c_d.run = 1'b0;
            c_d.en  = 1'b0;
        end

        if (mode_we) begin
            c_d.en   = wr_en_w;
            c_d.cont = wr_cont_w;
            c_d.tsel = wr_tsel_w;
            if (!wr_en_w) c_d.run = 1'b0;
        end

        if (init_we) c_d.init = init_wdata;
        if (pre_we)  c_d.pre  = pre_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.tsel <= TSEL_SOFT;
        end else begin
            c_q <= c_d;
        end
    end

    assign irq_eoc   = c_q.irq_eoc;
    assign irq_edge  = c_q.irq_edge;
    assign armed_o   = c_q.en;
    assign running_o = c_q.run;

    // R2
    eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eoc |=> !irq_eoc);

    // R4
    sp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_w && !c_q.cont && !start_w && !mode_we) |=> (!armed_o && !running_o));

    // R5
    cont_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_w && c_q.cont && !mode_we) |=> (running_o && irq_eoc));

    // R8
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_start_w && eoc_w && !mode_we) |=> (running_o && armed_o && irq_eoc));

    // R10
    idle_no_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !eoc_w);

endmodule

// File: tb/test_retrig_interval_timer.sv
module test_retrig_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b1;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wd = '0;
    logic       init_we = 1'b0;
    logic [7:0] init_wd = '0;
    logic       pre_we = 1'b0;
    logic [5:0] pre_wd = '0;
    logic       irq_eoc;
    logic       irq_edge;
    logic [7:0] count;
    logic       armed;
    logic       running;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural model state
    int m_h1 = 0, m_h2 = 0, m_h3 = 0;
    int m_en = 0, m_cont = 0, m_tsel = 0, m_run = 0;
    int m_init = 0, m_pre = 0;
    int m_el = 0, m_per = 8, m_n = 1;
    int m_eoc = 0, m_edge = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retrig_interval_timer i_retrig_interval_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig),
        .mode_we    (mode_we),
        .mode_wdata (mode_wd),
        .init_we    (init_we),
        .init_wdata (init_wd),
        .pre_we     (pre_we),
        .pre_wdata  (pre_wd),
        .irq_eoc    (irq_eoc),
        .irq_edge   (irq_edge),
        .count_o    (count),
        .armed_o    (armed),
        .running_o  (running)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // reference model: elapsed clocks since the last load
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h1 = 0; m_h2 = 0; m_h3 = 0;
            m_en = 0; m_cont = 0; m_tsel = 0; m_run = 0;
            m_init = 0; m_pre = 0; m_el = 0; m_eoc = 0; m_edge = 0;
        end else begin
            int fall, expire, start, pe, ne;
            fall = (m_h3 == 1 && m_h2 == 0);
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = trig;
            expire = m_run && (m_el + 1 == m_per * m_n);
            start  = (fall && m_tsel == 3 && m_en) ||
                     (mode_we && mode_wd[0] && !m_en && mode_wd[3:2] != 2'b11);
            pe = (m_pre == 0) ? 64 : m_pre;
            ne = (m_init == 0) ? 256 : m_init;
            m_eoc  = expire;
            m_edge = fall;
            if (start) begin
                m_run = 1; m_el = 0; m_per = 8 * pe; m_n = ne;
            end else if (expire) begin
                if (m_cont) begin
                    m_el = 0; m_per = 8 * pe; m_n = ne;
                end else begin
                    m_run = 0; m_en = 0;
                end
            end else if (m_run) begin
                m_el++;
            end
            if (mode_we) begin
                m_en = mode_wd[0]; m_cont = mode_wd[1]; m_tsel = mode_wd[3:2];
                if (!mode_wd[0]) m_run = 0;
            end
            if (init_we) m_init = init_wd;
            if (pre_we)  m_pre  = pre_wd;
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(irq_eoc == m_eoc, "R2", "irq_eoc vs model", irq_eoc, m_eoc);
            check(irq_edge == m_edge, "R6", "irq_edge vs model", irq_edge, m_edge);
            check(armed == m_en, "R4", "armed vs model", armed, m_en);
            check(running == m_run, "R10", "running vs model", running, m_run);
            if (m_run) begin
                int exp_cnt;
                exp_cnt = (m_n - m_el / m_per) & 255;
                check(count == exp_cnt, "R11", "count vs model", count, exp_cnt);
            end
        end
    end

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [3:0] v);
        mode_we = 1'b1; mode_wd = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic wr_init(input logic [7:0] v);
        init_we = 1'b1; init_wd = v;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    task automatic wr_pre(input logic [5:0] v);
        pre_we = 1'b1; pre_wd = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic wait_eoc(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_eoc && n < 6000);
    endtask

    task automatic fall_timed(output int n);
        trig = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 3) trig = 1'b1;
        end while (!irq_eoc && n < 6000);
        trig = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=%0d expected<%0d cycles", WDOG, WDOG);
        finish_run();
    end

    initial begin
        int n;
        int pulses;
        // mode values: bit0 enable, bit1 continuous, bits3:2 trigger select
        idle(3);
        check(irq_eoc == 0 && irq_edge == 0, "R1", "irqs in reset", irq_eoc + irq_edge, 0);
        check(armed == 0 && running == 0, "R1", "flags in reset", armed + running, 0);
        check(count == 0, "R1", "count in reset", count, 0);
        rst_n = 1'b1;
        idle(2);
        check(running == 0 && count == 0, "R1", "idle after reset", running, 0);

        // R2: basic retriggerable single-pass, T = 8*1*3 = 24
        wr_init(8'd3);
        wr_pre(6'd1);
        wr_mode(4'hD);
        idle(2);
        fall_timed(n);
        check(n == 27, "R2", "edge to eoc clocks", n, 27);
        idle(2);
        check(armed == 0, "R4", "enable cleared at eoc", armed, 0);

        // R4: edges ignored while disarmed
        trig = 1'b0; idle(3); trig = 1'b1; idle(30);
        check(running == 0, "R4", "edge ignored when disarmed", running, 0);
        wr_mode(4'hD);
        idle(2);
        fall_timed(n);
        check(n == 27, "R4", "rearmed edge to eoc", n, 27);

        // R3: retrigger 15 clocks after the first edge
        wr_mode(4'hD);
        idle(2);
        trig = 1'b0; idle(3); trig = 1'b1; idle(12);
        check(running == 1, "R3", "running before retrigger", running, 1);
        fall_timed(n);
        check(n == 27, "R3", "eoc measured from latest edge", n, 27);

        // R8: second edge detected on the expiry clock
        wr_mode(4'hD);
        idle(2);
        trig = 1'b0; idle(3); trig = 1'b1; idle(21);
        fall_timed(n);
        check(n == 3, "R8", "coincident eoc issued", n, 3);
        check(running == 1, "R8", "still running", running, 1);
        check(armed == 1, "R8", "still armed", armed, 1);
        wait_eoc(n);
        check(n == 24, "R8", "full interval after reload", n, 24);
        idle(2);
        check(running == 0, "R4", "single pass stops", running, 0);

        // R5: continuous
        wr_mode(4'hF);
        idle(2);
        fall_timed(n);
        check(n == 27, "R5", "first interval", n, 27);
        wait_eoc(n);
        check(n == 24, "R5", "second interval", n, 24);
        wait_eoc(n);
        check(n == 24, "R5", "third interval", n, 24);

        // R12: init write mid-interval affects the next load only
        wr_init(8'd5);
        wait_eoc(n);
        check(n == 23, "R12", "current interval unchanged", n, 23);
        wait_eoc(n);
        check(n == 40, "R12", "new interval after reload", n, 40);

        // R10: clearing enable stops counting
        wr_mode(4'hC);
        check(running == 0, "R10", "stopped on disable", running, 0);
        pulses = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (irq_eoc) pulses++;
        end
        check(pulses == 0, "R10", "no eoc after disable", pulses, 0);

        // R9: software mode, trigger does not restart, T = 16
        wr_init(8'd2);
        wr_pre(6'd1);
        wr_mode(4'h1);
        trig = 1'b0; idle(3); trig = 1'b1; idle(3);
        wait_eoc(n);
        check(n == 10, "R9", "software start ignores trigger", n, 10);

        // R7: zero prescale and zero initial count
        wr_init(8'd1);
        wr_pre(6'd0);
        wr_mode(4'h1);
        wait_eoc(n);
        check(n == 512, "R7", "prescale 0 is 64", n, 512);
        wr_init(8'd0);
        wr_pre(6'd1);
        wr_mode(4'h1);
        wait_eoc(n);
        check(n == 2048, "R7", "initial 0 is 256", n, 2048);

        // R6: edge interrupt while disarmed
        idle(4);
        trig = 1'b0;
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (irq_edge) pulses++;
        end
        trig = 1'b1;
        check(pulses == 1, "R6", "one edge pulse per fall", pulses, 1);
        idle(4);

        finish_run();
    end

endmodule